// File: doc/BRIEF.md
# Keyed Serial/Parallel Clock-Generator Control Register

This block is the control front end of an audio clock generator. It holds a mode register that drives six clock-output enable flags and a 3-bit sampling-frequency select. The register is loaded in one of two ways, chosen by a static mode input. In serial mode, three shared pins carry a latch-enable line, a data line and a shift clock, and a 16-bit control word is shifted in with the most significant bit first. In parallel mode, the same three pins are read directly as the three select bits, and all six enables are held on.

A serial word is committed only when three conditions hold. Its upper six bits must carry the fixed key `011100`, its reserved bit must be low, and exactly sixteen bits must have been clocked in while latch-enable was low. If any condition fails, the word is dropped and the register keeps its previous contents. All pins pass through synchronisers into the system clock domain. The shift clock and latch-enable are then handled through edge detection, so the serial link may run at any rate well below the system clock.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: A synchronous reset drives all six enables `out_en` to 1 and `fs_sel` to 000.
- R2: In serial mode (`par_sel`=0), a 16-bit word sent MSB first on `pin_dat` is committed when `pin_le` rises. Each bit is sampled on a rising `pin_sck` while `pin_le` is low. On commit, `out_en[5:0]` takes word bits 9..4 (bit 9 goes to `out_en[5]`, the first output) and `fs_sel` takes word bits 2..0.
- R3: A serial word whose bits 15..10 differ from `011100` is discarded, and both outputs keep their previous values.
- R4: A serial word with bit 3 set is discarded, and both outputs keep their previous values.
- R5: A frame containing more or fewer than 16 rising shift-clock edges is discarded. This holds even when the last 16 bits shifted in would form a valid word.
- R6: In serial mode, the outputs change only in the cycle after an accepted commit. While a frame is still being shifted in, the register keeps its old value.
- R7: In parallel mode (`par_sel`=1), `fs_sel` follows {`pin_le`, `pin_sck`, `pin_dat`} as select bits 2, 1 and 0, and `out_en` is held at all ones.
- R8: After a return from parallel to serial mode, the register keeps the last parallel selection with all enables on, until a valid serial word is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_sel | input | 1 | Control mode: 0 serial, 1 parallel |
| pin_le | input | 1 | Serial latch-enable / parallel select bit 2 |
| pin_dat | input | 1 | Serial data / parallel select bit 0 |
| pin_sck | input | 1 | Serial shift clock / parallel select bit 1 |
| out_en | output | 6 | Clock-output enables; bit 5 is the first output, 0 forces an output low |
| fs_sel | output | 3 | Sampling-frequency and rate select code |

## Verification
The assertions assume that every pin level is held for at least several system clocks, so that each shift-clock and latch-enable edge survives synchronisation as a single clean edge. They also assume that `par_sel` changes only while the serial pins are idle. The stimulus holds each data, shift-clock and latch level for three or more clocks. It switches modes only with latch-enable high and the shift clock low, and drives every pin on the falling clock edge.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;
  localparam int WORD_W  = 16;
  localparam int OUT_N   = 6;
  localparam int SEL_W   = 3;
  localparam int RSV_POS = SEL_W;
  localparam int EN_LO   = SEL_W + 1;
  localparam int EN_HI   = EN_LO + OUT_N - 1;
  localparam int KEY_LO  = EN_HI + 1;
  localparam int KEY_W   = WORD_W - KEY_LO;
  localparam int CNT_W   = $clog2(WORD_W) + 2;
  localparam logic [KEY_W-1:0] KEY_VAL = KEY_W'(6'b011100);

  typedef logic [WORD_W-1:0] ctrl_word_t;

  // key matches and reserved bit low
  function automatic logic word_accepts(input ctrl_word_t w);
    return (w[WORD_W-1:KEY_LO] == KEY_VAL) && !w[RSV_POS];
  endfunction

  function automatic logic [OUT_N-1:0] en_field(input ctrl_word_t w);
    return w[EN_HI:EN_LO];
  endfunction

  function automatic logic [SEL_W-1:0] sel_field(input ctrl_word_t w);
    return w[SEL_W-1:0];
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d_in;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_out = st[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift
  import clkgen_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             par_mode,
  input  logic             le_s,
  input  logic             sck_s,
  input  logic             dat_s,
  output ctrl_word_t       word,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             shift_pulse,
  output logic             le_rise
);
  logic le_prev, sck_prev, le_fall;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_prev  <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      le_prev  <= le_s;
      sck_prev <= sck_s;
    end
  end

  assign le_rise     = le_s & ~le_prev;
  assign le_fall     = ~le_s & le_prev;
  assign shift_pulse = sck_s & ~sck_prev & ~le_s & ~par_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (par_mode || le_rise || le_fall) begin
      bit_cnt <= '0;
    end else if (shift_pulse) begin
      word <= {word[WORD_W-2:0], dat_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_mode_reg.sv
module ctl_mode_reg
  import clkgen_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             par_mode,
  input  logic             commit,
  input  ctrl_word_t       word,
  input  logic [SEL_W-1:0] par_bits,
  output logic [OUT_N-1:0] out_en,
  output logic [SEL_W-1:0] fs_sel
);
  logic [OUT_N-1:0] en_next;
  assign en_next = en_field(word);

  for (genvar i = 0; i < OUT_N; i++) begin : g_en
    logic en_bit;
    always_ff @(posedge clk) begin
      if (rst || par_mode) en_bit <= 1'b1;
      else if (commit)     en_bit <= en_next[i];
    end
    assign out_en[i] = en_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)           fs_sel <= '0;
    else if (par_mode) fs_sel <= par_bits;
    else if (commit)   fs_sel <= sel_field(word);
  end
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_sel,
  input  logic             pin_le,
  input  logic             pin_dat,
  input  logic             pin_sck,
  output logic [OUT_N-1:0] out_en,
  output logic [SEL_W-1:0] fs_sel
);
  logic [3:0]       pins_s;
  logic             par_mode, le_s, dat_s, sck_s;
  ctrl_word_t       word;
  logic [CNT_W-1:0] bit_cnt;
  logic             shift_pulse, le_rise, commit;

  ctl_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({par_sel, pin_le, pin_sck, pin_dat}),
    .q_out(pins_s)
  );
  assign {par_mode, le_s, sck_s, dat_s} = pins_s;

  ctl_shift u_shift (
    .clk(clk), .rst(rst), .par_mode(par_mode),
    .le_s(le_s), .sck_s(sck_s), .dat_s(dat_s),
    .word(word), .bit_cnt(bit_cnt),
    .shift_pulse(shift_pulse), .le_rise(le_rise)
  );

  assign commit = le_rise && !par_mode &&
                  (bit_cnt == CNT_W'(WORD_W)) && word_accepts(word);

  ctl_mode_reg u_reg (
    .clk(clk), .rst(rst), .par_mode(par_mode), .commit(commit),
    .word(word), .par_bits({le_s, sck_s, dat_s}),
    .out_en(out_en), .fs_sel(fs_sel)
  );
endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk
  import clkgen_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             par_mode,
  input logic             commit,
  input logic             le_s,
  input logic             shift_pulse,
  input ctrl_word_t       word,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [OUT_N-1:0] out_en,
  input logic [SEL_W-1:0] fs_sel
);
  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_en == '1 && fs_sel == '0));
  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (out_en == $past(word[EN_HI:EN_LO]) && fs_sel == $past(word[SEL_W-1:0])));
  // R3
  key_match_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> word[WORD_W-1:KEY_LO] == 6'b011100);
  // R4
  reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> !word[RSV_POS]);
  // R5
  full_count_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> bit_cnt == CNT_W'(WORD_W));
  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && !commit) |=> ($stable(out_en) && $stable(fs_sel)));
  // R6
  shift_gate_chk: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |-> !le_s && !par_mode);
  // R7
  par_enables_chk: assert property (@(posedge clk) disable iff (rst)
    par_mode |=> out_en == '1);
endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (.*);

// File: tb/clkgen_mode_ctrl_test.sv
module clkgen_mode_ctrl_test;
  logic clk = 0, rst = 1, par_sel = 0, pin_le = 1, pin_dat = 0, pin_sck = 0;
  logic [5:0] out_en;
  logic [2:0] fs_sel;
  int total = 0, bad = 0;
  logic [5:0] exp_en;
  logic [2:0] exp_fs;

  always #10 clk = ~clk;

  clkgen_mode_ctrl uut (.clk(clk), .rst(rst), .par_sel(par_sel), .pin_le(pin_le),
    .pin_dat(pin_dat), .pin_sck(pin_sck), .out_en(out_en), .fs_sel(fs_sel));

  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h72A5, 16'h7150, 16'h700B, 16'h73F7,
                                       16'hF3F7, 16'h7003, 16'h6C12, 16'h7332};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      pin_dat = w[i]; tick(3);
      pin_sck = 1;    tick(3);
      pin_sck = 0;
    end
  endtask

  task automatic send(input logic [31:0] w, input int nb);
    pin_le = 0; tick(4);
    shift_bits(w, nb);
    tick(3); pin_le = 1; tick(8);
  endtask

  // bench model of acceptance: key 011100 in bits 15..10, bit 3 low, 16 bits
  task automatic model(input logic [15:0] w);
    if (w[15:10] == 6'b011100 && !w[3]) begin
      exp_en = w[9:4];
      exp_fs = w[2:0];
    end
  endtask

  initial begin
    tick(3); rst = 0; tick(2);
    exp_en = 6'h3F; exp_fs = 3'b000;
    check("R1 en", out_en, exp_en);
    check("R1 fs", fs_sel, exp_fs);

    // table walk: R2 valid words, R3 key mismatch, R4 reserved bit
    for (int v = 0; v < NV; v++) begin
      send(VEC[v], 16);
      model(VEC[v]);
      check("R2/R3/R4 en", out_en, exp_en);
      check("R2/R3/R4 fs", fs_sel, exp_fs);
    end

    // R5: 15 and 17 bits are dropped
    send(32'h7150 >> 1, 15);
    check("R5 short en", out_en, exp_en);
    check("R5 short fs", fs_sel, exp_fs);
    send(32'h07150, 17);
    check("R5 long en", out_en, exp_en);
    check("R5 long fs", fs_sel, exp_fs);

    // R6: mid-frame hold, then commit on latch rise
    pin_le = 0; tick(4);
    shift_bits(32'h7150, 16);
    tick(6);
    check("R6 hold en", out_en, exp_en);
    check("R6 hold fs", fs_sel, exp_fs);
    pin_le = 1; tick(8);
    check("R6 commit en", out_en, 6'h15);
    check("R6 commit fs", fs_sel, 3'b000);

    // R1: reset mid-run
    send(32'h7332, 16);
    rst = 1; tick(2); rst = 0; tick(1);
    check("R1 rerun en", out_en, 6'h3F);
    check("R1 rerun fs", fs_sel, 3'b000);
    send(32'h7003, 16);

    // R7: parallel mode, fs = {le, sck, dat}
    par_sel = 1; pin_le = 1; pin_sck = 1; pin_dat = 0; tick(8);
    check("R7 en", out_en, 6'h3F);
    check("R7 fs 110", fs_sel, 3'b110);
    pin_le = 0; pin_sck = 1; pin_dat = 1; tick(8);
    check("R7 fs 011", fs_sel, 3'b011);
    check("R7 en held", out_en, 6'h3F);

    // R8: back to serial keeps last parallel selection
    pin_le = 1; pin_sck = 0; pin_dat = 1; tick(8);
    par_sel = 0; tick(8);
    check("R8 en", out_en, 6'h3F);
    check("R8 fs", fs_sel, 3'b101);
    send(32'h72A5, 16);
    check("R8 serial again en", out_en, 6'h2A);
    check("R8 serial again fs", fs_sel, 3'b101);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule